// File: doc/BRIEF.md
# Accumulator Partial-Load Insertion Unit

This unit is the write side of a register file that holds two 32-bit accumulators (A and B) and one 64-bit double accumulator (D). Each cycle, a decoder may present one load operation together with an operand that has already been fetched. The operation can place the whole operand into A, B or D. It can splice a 16-bit or 8-bit piece into a chosen lane of A, with the other lanes either kept or zeroed. It can also load the absolute value of the operand. Operand fetch, address arithmetic and decode are done elsewhere.

A 2-bit lane/target field (`m_i`) chooses the destination or lane. A literal flag says that the operand is a short 18-bit signed immediate rather than a fetched word. A compare bit asks the unit to classify the written accumulator against zero. The accumulators, a 2-bit condition code and an overflow flag are all registered. They change together on the clock edge that accepts the operation. Lanes are numbered from the most significant end: "leftmost" means the most significant byte or half.

Top module: `acc_load_unit`

## Requirements
- R1: A synchronous active-high reset clears A, B, D, the condition code and the overflow flag to zero.
- R2: Byte insert (op code 2) writes the rightmost 8 operand bits into lane `m_i` of A. Lane 00 is bits 31:24, 01 is bits 23:16, 10 is bits 15:8 and 11 is bits 7:0. The other three bytes of A keep their values.
- R3: Byte insert-and-clear (op code 3) writes the same lane as R2 and sets every other bit of A to zero.
- R4: Half insert (op code 1) takes the rightmost 16 operand bits. With `m_i`=01 they go to bits 31:16 and the right half is kept. With 10 they go to bits 15:0 and the left half is kept. With 11 they go to bits 15:0 and bits 31:16 become copies of operand bit 15. With 00 nothing changes.
- R5: Word load (op code 0) writes A for `m_i`=01, B for 10 and D for 11. A and B take the rightmost 32 operand bits; D takes all 64. With 00 nothing changes.
- R6: When the literal flag is set on a word or magnitude load, the rightmost 18 operand bits are sign-extended to the width of the destination. Half and byte inserts use the rightmost 16 or 8 bits whatever the flag.
- R7: Magnitude load (op code 4) uses the same targets as R5. It writes the two's complement negation of a negative operand and writes a non-negative operand unchanged.
- R8: A magnitude load of the most negative value of the destination width sets the overflow flag and writes that same value. Every other accepted operation clears the flag.
- R9: With `c_i`=1, the condition code becomes 1 if the whole destination is negative, 2 if it is zero and 3 if it is positive. This is judged on the value written, and the code updates in the same cycle as the write.
- R10: With `c_i`=0, an accepted operation leaves the condition code unchanged.
- R11: With `valid_i` low, or with op codes 5 to 7, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | 0 word, 1 half, 2 byte, 3 byte-clear, 4 magnitude |
| m_i | input | 2 | Target accumulator or lane |
| c_i | input | 1 | Update condition code |
| lit_i | input | 1 | Operand is an 18-bit literal |
| opnd_i | input | 64 | Fetched operand, right-aligned |
| acc_a_o | output | 32 | Accumulator A |
| acc_b_o | output | 32 | Accumulator B |
| acc_d_o | output | 64 | Double accumulator D |
| cond_o | output | 2 | Condition code |
| ovf_o | output | 1 | Overflow flag of last accepted operation |

## Verification
The assertions assume that `valid_i`, `op_i`, `m_i` and `c_i` carry defined levels on every clock edge after reset, and that `valid_i` stays low while reset is high. They treat op codes 5 to 7 and target 00 on word-style operations as legal stimulus that must leave state untouched. The bench holds `valid_i` low through reset. It drives only fully defined values and changes them on the falling edge, away from the sampling edge. It sweeps every op code, target, compare bit and literal flag over a fixed set of operands. That set includes both most negative values and an 18-bit literal with its sign bit set.

// File: rtl/acc_load_pkg.sv
package acc_load_pkg;
  typedef enum logic [2:0] {
    OP_WORD     = 3'd0,
    OP_HALF     = 3'd1,
    OP_BYTE     = 3'd2,
    OP_BYTE_CLR = 3'd3,
    OP_MAG      = 3'd4
  } load_op_e;

  localparam logic [1:0] CC_NEG  = 2'd1;
  localparam logic [1:0] CC_ZERO = 2'd2;
  localparam logic [1:0] CC_POS  = 2'd3;
endpackage

// File: rtl/acc_sign_class.sv
module acc_sign_class #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  output logic [1:0]   cc_o
);
  import acc_load_pkg::*;

  always_comb begin
    if (val_i[W-1])       cc_o = CC_NEG;
    else if (val_i == '0) cc_o = CC_ZERO;
    else                  cc_o = CC_POS;
  end
endmodule

// File: rtl/acc_word_shaper.sv
module acc_word_shaper #(
  parameter int W     = 32,
  parameter int LIT_W = 18
) (
  input  logic [W-1:0] opnd_i,
  input  logic         lit_i,
  input  logic         mag_i,
  output logic [W-1:0] val_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] ext;

  always_comb begin
    if (lit_i) ext = {{(W-LIT_W){opnd_i[LIT_W-1]}}, opnd_i[LIT_W-1:0]};
    else       ext = opnd_i;
    if (mag_i && ext[W-1]) val_o = ~ext + 1'b1;
    else                   val_o = ext;
    ovf_o = mag_i && (ext == MOST_NEG);
  end
endmodule

// File: rtl/acc_lane_merge.sv
module acc_lane_merge #(
  parameter int W  = 32,
  parameter int BW = 8
) (
  input  logic [W-1:0]          cur_i,
  input  acc_load_pkg::load_op_e op_i,
  input  logic [1:0]            m_i,
  input  logic [W/2-1:0]        src_i,
  output logic [W-1:0]          nxt_o
);
  import acc_load_pkg::*;

  localparam int LANES = W / BW;
  localparam int HALF_LANES = LANES / 2;
  localparam int HW = W / 2;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int HI = W - 1 - BW * k;
    localparam int J  = k % HALF_LANES;
    localparam bit LEFT = (k < HALF_LANES);
    logic pick;
    logic [BW-1:0] half_byte;
    assign pick = (m_i == 2'(k));
    assign half_byte = src_i[HW-1-BW*J -: BW];

    always_comb begin
      nxt_o[HI -: BW] = cur_i[HI -: BW];
      unique case (op_i)
        OP_BYTE:     if (pick) nxt_o[HI -: BW] = src_i[BW-1:0];
        OP_BYTE_CLR: nxt_o[HI -: BW] = pick ? src_i[BW-1:0] : '0;
        OP_HALF: begin
          if (LEFT) begin
            if (m_i == 2'b01)      nxt_o[HI -: BW] = half_byte;
            else if (m_i == 2'b11) nxt_o[HI -: BW] = {BW{src_i[HW-1]}};
          end else if (m_i[1]) begin
            nxt_o[HI -: BW] = half_byte;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_load_unit.sv
module acc_load_unit #(
  parameter int WORD_W = 32,
  parameter int DBL_W  = 64,
  parameter int LIT_W  = 18,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        m_i,
  input  logic              c_i,
  input  logic              lit_i,
  input  logic [DBL_W-1:0]  opnd_i,
  output logic [WORD_W-1:0] acc_a_o,
  output logic [WORD_W-1:0] acc_b_o,
  output logic [DBL_W-1:0]  acc_d_o,
  output logic [1:0]        cond_o,
  output logic              ovf_o
);
  import acc_load_pkg::*;

  localparam int HW = WORD_W / 2;

  load_op_e op;
  assign op = load_op_e'(op_i);

  logic word_like, is_mag, legal;
  assign word_like = (op == OP_WORD) || (op == OP_MAG);
  assign is_mag    = (op == OP_MAG);

  always_comb begin
    legal = 1'b0;
    if (valid_i) begin
      unique case (op)
        OP_WORD, OP_MAG, OP_HALF: legal = (m_i != 2'b00);
        OP_BYTE, OP_BYTE_CLR:     legal = 1'b1;
        default:                  legal = 1'b0;
      endcase
    end
  end

  logic [WORD_W-1:0] w_val, lane_val;
  logic [DBL_W-1:0]  d_val;
  logic              w_ovf, d_ovf;

  acc_word_shaper #(.W(WORD_W), .LIT_W(LIT_W)) u_shape_w (
    .opnd_i(opnd_i[WORD_W-1:0]), .lit_i(lit_i), .mag_i(is_mag),
    .val_o(w_val), .ovf_o(w_ovf)
  );

  acc_word_shaper #(.W(DBL_W), .LIT_W(LIT_W)) u_shape_d (
    .opnd_i(opnd_i), .lit_i(lit_i), .mag_i(is_mag),
    .val_o(d_val), .ovf_o(d_ovf)
  );

  acc_lane_merge #(.W(WORD_W), .BW(BYTE_W)) u_merge (
    .cur_i(acc_a_o), .op_i(op), .m_i(m_i), .src_i(opnd_i[HW-1:0]),
    .nxt_o(lane_val)
  );

  logic [WORD_W-1:0] a_nxt, b_nxt, word_dest;
  logic [DBL_W-1:0]  d_nxt;
  logic              dest_is_d, ovf_nxt;
  logic [1:0]        cc_word, cc_dbl, cc_nxt;

  always_comb begin
    a_nxt = acc_a_o;
    b_nxt = acc_b_o;
    d_nxt = acc_d_o;
    dest_is_d = 1'b0;
    ovf_nxt = 1'b0;
    if (word_like) begin
      unique case (m_i)
        2'b01: begin a_nxt = w_val; ovf_nxt = is_mag && w_ovf; end
        2'b10: begin b_nxt = w_val; ovf_nxt = is_mag && w_ovf; end
        2'b11: begin d_nxt = d_val; ovf_nxt = is_mag && d_ovf; dest_is_d = 1'b1; end
        default: ;
      endcase
    end else begin
      a_nxt = lane_val;
    end
    word_dest = (word_like && m_i == 2'b10) ? b_nxt : a_nxt;
  end

  acc_sign_class #(.W(WORD_W)) u_cc_w (.val_i(word_dest), .cc_o(cc_word));
  acc_sign_class #(.W(DBL_W))  u_cc_d (.val_i(d_nxt),     .cc_o(cc_dbl));

  assign cc_nxt = dest_is_d ? cc_dbl : cc_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_a_o <= '0;
      acc_b_o <= '0;
      acc_d_o <= '0;
      cond_o  <= '0;
      ovf_o   <= 1'b0;
    end else if (legal) begin
      acc_a_o <= a_nxt;
      acc_b_o <= b_nxt;
      acc_d_o <= d_nxt;
      ovf_o   <= ovf_nxt;
      if (c_i) cond_o <= cc_nxt;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!valid_i || op_i > 3'd4) |=> ($stable(acc_a_o) && $stable(acc_b_o)
      && $stable(acc_d_o) && $stable(cond_o) && $stable(ovf_o))); // R11

  AST_COND_KEPT: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !c_i) |=> $stable(cond_o)); // R10

  AST_COND_CODED: assert property (@(posedge clk) disable iff (rst)
    (legal && c_i) |=> (cond_o != 2'b00)); // R9

  AST_OVF_MAG_ONLY: assert property (@(posedge clk) disable iff (rst)
    (legal && op_i != 3'd4) |=> !ovf_o); // R8

  AST_MAG_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd4 && m_i == 2'b01) |=> (!acc_a_o[WORD_W-1] || ovf_o)); // R7

  AST_BYTE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd2 && m_i == 2'b00)
      |=> (acc_a_o[WORD_W-BYTE_W-1:0] == $past(acc_a_o[WORD_W-BYTE_W-1:0]))); // R2

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd3 && m_i == 2'b11)
      |=> (acc_a_o[WORD_W-1:BYTE_W] == '0)); // R3

  AST_BD_UNTOUCHED_BY_LANES: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (op_i == 3'd1 || op_i == 3'd2 || op_i == 3'd3))
      |=> ($stable(acc_b_o) && $stable(acc_d_o))); // R4
endmodule

// File: tb/sim_acc_load_unit.sv
module sim_acc_load_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  m_i = '0;
  logic        c_i = 1'b0;
  logic        lit_i = 1'b0;
  logic [63:0] opnd_i = '0;
  logic [31:0] acc_a_o, acc_b_o;
  logic [63:0] acc_d_o;
  logic [1:0]  cond_o;
  logic        ovf_o;

  int errors = 0;
  int checks = 0;

  logic [31:0] ra = '0, rb = '0;
  logic [63:0] rd = '0;
  logic [1:0]  rcc = '0;
  logic        rovf = 1'b0;

  always #2 clk = ~clk;

  acc_load_unit u0 (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .m_i(m_i),
    .c_i(c_i), .lit_i(lit_i), .opnd_i(opnd_i), .acc_a_o(acc_a_o),
    .acc_b_o(acc_b_o), .acc_d_o(acc_d_o), .cond_o(cond_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [1:0] sign_code(input longint v);
    if (v < 0) return 2'd1;
    if (v == 0) return 2'd2;
    return 2'd3;
  endfunction

  // Reference model written arithmetically from the requirements.
  task automatic model(input logic [2:0] op, input logic [1:0] m, input logic c,
                       input logic lit, input logic [63:0] x);
    longint lit_v, w32;
    logic [63:0] v64;
    logic [31:0] v32;
    logic [31:0] h, b8;
    int sh;
    logic do_w, ov;
    lit_v = longint'(x % 64'd262144);
    if (lit_v >= 131072) lit_v = lit_v - 262144;
    h  = 32'(x % 64'd65536);
    b8 = 32'(x % 64'd256);
    if (op > 3'd4) return;                          // R11
    if ((op == 3'd0 || op == 3'd4 || op == 3'd1) && m == 2'b00) return;
    ov = 1'b0;
    if (op == 3'd2 || op == 3'd3) begin             // R2 R3
      sh = 8 * (3 - int'(m));
      if (op == 3'd2) ra = (ra & ~(32'hFF << sh)) | (b8 << sh);
      else            ra = b8 << sh;
      if (c) rcc = sign_code(longint'($signed(ra)));
    end else if (op == 3'd1) begin                  // R4
      if (m == 2'b01)      ra = (ra % 32'h10000) + h * 32'h10000;
      else if (m == 2'b10) ra = (ra - (ra % 32'h10000)) + h;
      else                 ra = (h >= 32'h8000) ? (h + 32'hFFFF0000) : h;
      if (c) rcc = sign_code(longint'($signed(ra)));
    end else begin                                  // R5 R6 R7 R8
      do_w = 1'b1;
      if (m == 2'b11) begin
        v64 = lit ? 64'(lit_v) : x;
        if (op == 3'd4 && $signed(v64) < 0) begin
          ov = (v64 == 64'h8000_0000_0000_0000);
          v64 = 64'd0 - v64;
        end
        rd = v64;
        if (c) rcc = ($signed(rd) < 0) ? 2'd1 : (rd == 0 ? 2'd2 : 2'd3);
      end else begin
        w32 = lit ? lit_v : longint'($signed(x[31:0]));
        if (op == 3'd4 && w32 < 0) begin
          ov = (w32 == -longint'(64'h8000_0000));
          w32 = -w32;
        end
        v32 = 32'(w32);
        if (m == 2'b01) ra = v32; else rb = v32;
        if (c) rcc = sign_code(longint'($signed(v32)));
      end
      if (do_w) ;
    end
    rovf = ov;
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic lit);
    case (op)
      3'd0: return lit ? "R6 word literal" : "R5 word";
      3'd1: return "R4 half";
      3'd2: return "R2 byte";
      3'd3: return "R3 byte clear";
      3'd4: return lit ? "R6 magnitude literal" : "R7 magnitude";
      default: return "R11 unknown op";
    endcase
  endfunction

  task automatic apply(input logic v, input logic [2:0] op, input logic [1:0] m,
                       input logic c, input logic lit, input logic [63:0] x);
    string t;
    @(negedge clk);
    valid_i = v; op_i = op; m_i = m; c_i = c; lit_i = lit; opnd_i = x;
    @(negedge clk);
    valid_i = 1'b0;
    if (v) model(op, m, c, lit, x);
    t = v ? tag_of(op, lit) : "R11 idle";
    chk({t, " A"}, 64'(acc_a_o), 64'(ra));
    chk({t, " B"}, 64'(acc_b_o), 64'(rb));
    chk({t, " D"}, acc_d_o, rd);
    chk(c ? "R9 cond" : "R10 cond kept", 64'(cond_o), 64'(rcc));
    chk("R8 overflow", 64'(ovf_o), 64'(rovf));
  endtask

  logic [63:0] pats [0:6];

  initial begin
    pats[0] = 64'h0;
    pats[1] = 64'h0000_0000_0000_0001;
    pats[2] = 64'hFFFF_FFFF_8000_0000;
    pats[3] = 64'h8000_0000_0000_0000;
    pats[4] = 64'h1234_5678_9ABC_DEF0;
    pats[5] = 64'h0000_0000_0002_0000;
    pats[6] = 64'hFEDC_0000_0000_80FF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset A", 64'(acc_a_o), 64'h0);
    chk("R1 reset B", 64'(acc_b_o), 64'h0);
    chk("R1 reset D", acc_d_o, 64'h0);
    chk("R1 reset cond", 64'(cond_o), 64'h0);
    chk("R1 reset ovf", 64'(ovf_o), 64'h0);

    // directed corners
    apply(1'b1, 3'd4, 2'b01, 1'b1, 1'b0, 64'h0000_0000_8000_0000); // R8 A min
    apply(1'b1, 3'd4, 2'b11, 1'b1, 1'b0, 64'h8000_0000_0000_0000); // R8 D min
    apply(1'b1, 3'd0, 2'b01, 1'b1, 1'b1, 64'h0000_0000_0003_FFFF); // R6 -1
    apply(1'b0, 3'd0, 2'b10, 1'b1, 1'b0, 64'h5555_5555_5555_5555); // R11 idle

    for (int op = 0; op < 8; op++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c < 2; c++)
          for (int l = 0; l < 2; l++)
            for (int p = 0; p < 7; p++)
              apply(1'b1, 3'(op), 2'(m), 1'(c), 1'(l), pats[p] ^ {32'h0, 8'(op*37+m), 24'h0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4ns * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule